// File: doc/BRIEF.md
# Accumulator Register Bank with Loop Counter

This block holds the three 8-bit working registers of a small accumulator processor. The primary accumulator `aa` is the register the ALU writes back into. The secondary register `ab` can be copied to and from the accumulator, cleared and incremented. The auxiliary register `ac` is used for scratch storage and as a loop counter. `ac` is reachable only through copies to and from `aa`, a synchronous clear, and its own increment. That increment also writes the zero flag.

Each cycle a decoded 8-bit opcode is presented together with a strobe. The opcode is translated into one operation class. Opcodes the bank does not recognise are left to other units, and the bank's state stays as it was. In the same strobed cycle the ALU can write its result into `aa`. The ALU result then takes priority over any copy into `aa`, while the other registers still carry out the opcode using the old `aa`.

Top module: `acc_bank`

## Requirements
- R1: While `rst_n` is low, `aa`, `ab`, `ac` and `z` are all zero.
- R2: Opcode 0x40 copies `ab` into `aa`, and opcode 0x41 copies `ac` into `aa`, on the clock edge that samples the strobe.
- R3: Opcode 0x48 copies `aa` into `ab`, and opcode 0x49 copies `aa` into `ac`.
- R4: Opcode 0x63 sets `ac` to `ac`+1 modulo 256. It sets `z` to 1 when the new `ac` is 0x00 and to 0 otherwise.
- R5: Opcode 0x62 sets `ab` to `ab`+1 modulo 256 and leaves `z` unchanged, including on wrap.
- R6: Opcode 0x69 clears `ab` and opcode 0x6A clears `ac`. Neither one changes `aa` or `z`.
- R7: Opcode 0x00 leaves every register and `z` unchanged.
- R8: With `op_valid_i` low, no register and no flag changes, whatever the other inputs are.
- R9: An opcode outside {0x00, 0x40, 0x41, 0x48, 0x49, 0x62, 0x63, 0x69, 0x6A}, with `alu_we_i` low, leaves all state unchanged.
- R10: With `op_valid_i` and `alu_we_i` both high, `aa` takes `alu_res_i`, even when the opcode is 0x40 or 0x41. In that cycle 0x48 and 0x49 store the old `aa`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 8 | Decoded instruction opcode |
| op_valid_i | input | 1 | Instruction strobe; state changes only when high |
| alu_we_i | input | 1 | Write the ALU result into `aa` this strobe |
| alu_res_i | input | 8 | ALU result |
| aa_o | output | 8 | Primary accumulator |
| ab_o | output | 8 | Secondary register |
| ac_o | output | 8 | Auxiliary register / loop counter |
| z_o | output | 1 | Zero flag from the counter increment |

## Verification
Two things can land on `aa` in the same edge: the ALU write-back and a register copy. The bench pairs `alu_we_i` with opcodes 0x40 and 0x41, and checks that `aa` holds the ALU value and not the copied register. It then pairs `alu_we_i` with 0x48 and 0x49, and checks that `ab` or `ac` receives the accumulator value from before the edge rather than the ALU value. A model in the bench, built from the requirements, predicts every register after each edge.

// File: rtl/acc_bank_pkg.sv
package acc_bank_pkg;

    localparam int unsigned OPW = 8;

    localparam logic [OPW-1:0] OPC_NOP     = 8'h00;
    localparam logic [OPW-1:0] OPC_B_TO_A  = 8'h40;
    localparam logic [OPW-1:0] OPC_C_TO_A  = 8'h41;
    localparam logic [OPW-1:0] OPC_A_TO_B  = 8'h48;
    localparam logic [OPW-1:0] OPC_A_TO_C  = 8'h49;
    localparam logic [OPW-1:0] OPC_INC_B   = 8'h62;
    localparam logic [OPW-1:0] OPC_INC_C   = 8'h63;
    localparam logic [OPW-1:0] OPC_CLR_B   = 8'h69;
    localparam logic [OPW-1:0] OPC_CLR_C   = 8'h6A;

    typedef enum logic [3:0] {
        K_IDLE,
        K_B_TO_A,
        K_C_TO_A,
        K_A_TO_B,
        K_A_TO_C,
        K_INC_B,
        K_INC_C,
        K_CLR_B,
        K_CLR_C
    } op_kind_e;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
    import acc_bank_pkg::*;
(
    input  logic [OPW-1:0] op_i,
    input  logic           op_valid_i,
    output op_kind_e       kind_o
);

    always_comb begin
        kind_o = K_IDLE;
        if (op_valid_i) begin
            unique case (op_i)
                OPC_B_TO_A: kind_o = K_B_TO_A;
                OPC_C_TO_A: kind_o = K_C_TO_A;
                OPC_A_TO_B: kind_o = K_A_TO_B;
                OPC_A_TO_C: kind_o = K_A_TO_C;
                OPC_INC_B:  kind_o = K_INC_B;
                OPC_INC_C:  kind_o = K_INC_C;
                OPC_CLR_B:  kind_o = K_CLR_B;
                OPC_CLR_C:  kind_o = K_CLR_C;
                default:    kind_o = K_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/acc_reg.sv
module acc_reg #(
    parameter int unsigned W       = 8,
    parameter bit          HAS_INC = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         ld_i,
    input  logic         inc_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o,
    output logic         wrap_o
);

    logic [W-1:0] nxt;

    generate
        if (HAS_INC) begin : g_inc
            always_comb begin
                if (clr_i)      nxt = '0;
                else if (ld_i)  nxt = d_i;
                else if (inc_i) nxt = q_o + W'(1);
                else            nxt = q_o;
            end
            assign wrap_o = &q_o;
        end else begin : g_plain
            always_comb begin
                if (clr_i)                 nxt = '0;
                else if (ld_i || inc_i)    nxt = ld_i ? d_i : q_o;
                else                       nxt = q_o;
            end
            assign wrap_o = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= nxt;
    end

endmodule

// File: rtl/acc_bank.sv
module acc_bank
    import acc_bank_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [OPW-1:0] op_i,
    input  logic           op_valid_i,
    input  logic           alu_we_i,
    input  logic [W-1:0]   alu_res_i,
    output logic [W-1:0]   aa_o,
    output logic [W-1:0]   ab_o,
    output logic [W-1:0]   ac_o,
    output logic           z_o
);

    op_kind_e     kind;
    logic         alu_take;
    logic         aa_ld;
    logic [W-1:0] aa_d;
    logic         aa_wrap, ab_wrap, ac_wrap;
    logic         z_q;

    acc_decode u_dec (
        .op_i       (op_i),
        .op_valid_i (op_valid_i),
        .kind_o     (kind)
    );

    assign alu_take = op_valid_i && alu_we_i;

    always_comb begin
        aa_ld = alu_take;
        aa_d  = alu_res_i;
        if (!alu_take) begin
            unique case (kind)
                K_B_TO_A: begin aa_ld = 1'b1; aa_d = ab_o; end
                K_C_TO_A: begin aa_ld = 1'b1; aa_d = ac_o; end
                default:  begin aa_ld = 1'b0; aa_d = alu_res_i; end
            endcase
        end
    end

    acc_reg #(.W(W), .HAS_INC(1'b0)) u_aa (
        .clk(clk), .rst_n(rst_n),
        .clr_i(1'b0), .ld_i(aa_ld), .inc_i(1'b0), .d_i(aa_d),
        .q_o(aa_o), .wrap_o(aa_wrap)
    );

    acc_reg #(.W(W), .HAS_INC(1'b1)) u_ab (
        .clk(clk), .rst_n(rst_n),
        .clr_i(kind == K_CLR_B), .ld_i(kind == K_A_TO_B),
        .inc_i(kind == K_INC_B), .d_i(aa_o),
        .q_o(ab_o), .wrap_o(ab_wrap)
    );

    acc_reg #(.W(W), .HAS_INC(1'b1)) u_ac (
        .clk(clk), .rst_n(rst_n),
        .clr_i(kind == K_CLR_C), .ld_i(kind == K_A_TO_C),
        .inc_i(kind == K_INC_C), .d_i(aa_o),
        .q_o(ac_o), .wrap_o(ac_wrap)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                z_q <= 1'b0;
        else if (kind == K_INC_C)  z_q <= ac_wrap;
    end

    assign z_o = z_q;

    logic unused_wrap;
    assign unused_wrap = aa_wrap ^ ab_wrap;

endmodule

// File: rtl/acc_bank_chk.sv
module acc_bank_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [7:0]   op_i,
    input logic         op_valid_i,
    input logic         alu_we_i,
    input logic [W-1:0] alu_res_i,
    input logic [W-1:0] aa_o,
    input logic [W-1:0] ab_o,
    input logic [W-1:0] ac_o,
    input logic         z_o
);

    always @(negedge clk) if (!rst_n) AST_RESET_ZERO: assert (aa_o == '0 && ab_o == '0 && ac_o == '0 && !z_o); // R1

    AST_COPY_B_TO_A: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid_i && !alu_we_i && op_i == 8'h40 |=> aa_o == $past(ab_o)); // R2

    AST_COPY_A_TO_C: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid_i && op_i == 8'h49 |=> ac_o == $past(aa_o)); // R3

    AST_INCC_ZFLAG: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid_i && op_i == 8'h63 |=> z_o == (ac_o == '0)); // R4

    AST_INCB_KEEPS_Z: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid_i && op_i == 8'h62 |=> $stable(z_o)); // R5

    AST_NOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid_i && !alu_we_i && op_i == 8'h00 |=>
        $stable(aa_o) && $stable(ab_o) && $stable(ac_o) && $stable(z_o)); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid_i |=> $stable(aa_o) && $stable(ab_o) && $stable(ac_o) && $stable(z_o)); // R8

    AST_ALU_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid_i && alu_we_i |=> aa_o == $past(alu_res_i)); // R10

endmodule

bind acc_bank acc_bank_chk #(.W(W)) chk_i (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .op_valid_i(op_valid_i),
    .alu_we_i(alu_we_i), .alu_res_i(alu_res_i),
    .aa_o(aa_o), .ab_o(ab_o), .ac_o(ac_o), .z_o(z_o)
);

// File: tb/acc_bank_tb.sv
module acc_bank_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] op_i = 8'h00;
    logic       op_valid_i = 1'b0;
    logic       alu_we_i = 1'b0;
    logic [7:0] alu_res_i = 8'h00;
    logic [7:0] aa_o, ab_o, ac_o;
    logic       z_o;

    int total = 0;
    int bad = 0;
    logic [7:0] m_aa = 0, m_ab = 0, m_ac = 0;
    logic       m_z = 0;

    always #5 clk = ~clk;

    acc_bank dut_i (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .op_valid_i(op_valid_i),
        .alu_we_i(alu_we_i), .alu_res_i(alu_res_i),
        .aa_o(aa_o), .ab_o(ab_o), .ac_o(ac_o), .z_o(z_o)
    );

    task automatic check(input string req);
        total++;
        if (aa_o !== m_aa || ab_o !== m_ab || ac_o !== m_ac || z_o !== m_z) begin
            bad++;
            $display("FAIL %s: actual aa=%h ab=%h ac=%h z=%b expected aa=%h ab=%h ac=%h z=%b",
                     req, aa_o, ab_o, ac_o, z_o, m_aa, m_ab, m_ac, m_z);
        end
    endtask

    // Drive one cycle, update the model from the requirements, compare after the edge.
    task automatic issue(input logic [7:0] op, input logic v, input logic we,
                         input logic [7:0] res, input string req);
        logic [7:0] o_aa;
        o_aa = m_aa;
        @(negedge clk);
        op_i = op; op_valid_i = v; alu_we_i = we; alu_res_i = res;
        if (v) begin
            if (we) m_aa = res;
            else if (op == 8'h40) m_aa = m_ab;
            else if (op == 8'h41) m_aa = m_ac;
            case (op)
                8'h48: m_ab = o_aa;
                8'h49: m_ac = o_aa;
                8'h62: m_ab = m_ab + 8'd1;
                8'h63: begin m_ac = m_ac + 8'd1; m_z = (m_ac == 8'h00); end
                8'h69: m_ab = 8'h00;
                8'h6A: m_ac = 8'h00;
                default: ;
            endcase
        end
        @(posedge clk); #1;
        check(req);
        @(negedge clk);
        op_valid_i = 1'b0; alu_we_i = 1'b0;
    endtask

    task automatic t_reset();
        #1; check("R1");
        @(negedge clk); rst_n = 1'b1;
        #1; check("R1");
    endtask

    task automatic t_moves();
        issue(8'h00, 1, 1, 8'h5A, "R10");
        issue(8'h48, 1, 0, 8'h00, "R3");
        issue(8'h00, 1, 1, 8'hC3, "R10");
        issue(8'h49, 1, 0, 8'h00, "R3");
        issue(8'h40, 1, 0, 8'h00, "R2");
        issue(8'h41, 1, 0, 8'h00, "R2");
    endtask

    task automatic t_counter();
        issue(8'h00, 1, 1, 8'hFE, "R10");
        issue(8'h49, 1, 0, 8'h00, "R3");
        issue(8'h63, 1, 0, 8'h00, "R4");
        issue(8'h63, 1, 0, 8'h00, "R4");
        issue(8'h63, 1, 0, 8'h00, "R4");
        issue(8'h48, 1, 0, 8'h00, "R3");
        issue(8'h63, 1, 0, 8'h00, "R4");
        issue(8'h6A, 1, 0, 8'h00, "R6");
        issue(8'h63, 1, 0, 8'h00, "R4");
        issue(8'h6A, 1, 0, 8'h00, "R6");
        issue(8'h00, 1, 1, 8'hFF, "R10");
        issue(8'h49, 1, 0, 8'h00, "R3");
        issue(8'h63, 1, 0, 8'h00, "R4");
    endtask

    task automatic t_incb();
        issue(8'h00, 1, 1, 8'hFF, "R10");
        issue(8'h48, 1, 0, 8'h00, "R3");
        issue(8'h62, 1, 0, 8'h00, "R5");
        issue(8'h62, 1, 0, 8'h00, "R5");
        issue(8'h69, 1, 0, 8'h00, "R6");
    endtask

    task automatic t_ignored();
        issue(8'h00, 1, 1, 8'h77, "R10");
        issue(8'h49, 1, 0, 8'h00, "R3");
        issue(8'h00, 1, 0, 8'h00, "R7");
        issue(8'h40, 0, 1, 8'h11, "R8");
        issue(8'h63, 0, 0, 8'h00, "R8");
        issue(8'h6A, 0, 0, 8'h00, "R8");
        issue(8'h01, 1, 0, 8'h00, "R9");
        issue(8'h4A, 1, 0, 8'h00, "R9");
        issue(8'h64, 1, 0, 8'h00, "R9");
        issue(8'hFF, 1, 0, 8'h00, "R9");
    endtask

    task automatic t_collide();
        issue(8'h40, 1, 1, 8'h3C, "R10");
        issue(8'h41, 1, 1, 8'h81, "R10");
        issue(8'h48, 1, 1, 8'h99, "R10");
        issue(8'h49, 1, 1, 8'h0F, "R10");
        issue(8'h63, 1, 1, 8'h22, "R10");
    endtask

    initial begin
        t_reset();
        t_moves();
        t_counter();
        t_incb();
        t_ignored();
        t_collide();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule